// File: doc/BRIEF.md
# Display Command Stream Register Decoder

This block sits on a byte stream that carries display-controller commands. It takes one byte on each cycle where `in_valid` is high. It recognises two commands that open with the same lead byte. The first writes one register in a bank of 8-bit video control registers. The second asks for a pixel copy, and the block presents it as a one-cycle request that carries the source address, the pixel count and the destination address. The block does not carry out the copy.

Register address 0xFF is a lock control. While the bank is locked, register writes go only to a shadow bank, and the live bank that drives the display does not change. Unlocking moves the whole shadow bank into the live bank in one cycle and raises a commit strobe. Bytes that cannot start a command, and commands with an unknown opcode, are dropped. The decoder then waits for the next lead byte.

The block also presents decoded views of the live registers. The base pointers are stored high byte first. The pixel clock is stored low byte first.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset the bank is unlocked and every live register is 0x00, except blanking register 0x1F, which reads 0x07 (power-down). `commit_o` and `copy_valid_o` are low.
- R2: The byte sequence 0xAF, 0x20, A, D is a register write. When the bank is unlocked and A < NREG, live register A reads D in the cycle after the handshake of D.
- R3: Writing 0x00 to address 0xFF locks the bank. While the bank is locked, writes to addresses below NREG leave every live register unchanged.
- R4: Writing 0xFF to address 0xFF while the bank is locked clears the lock. In the same cycle, every register written during the lock shows its latest value in the live bank, and `commit_o` is high for exactly that one cycle. An unlock sent while the bank is already unlocked raises no commit. Any other data value written to 0xFF has no effect.
- R5: The byte sequence 0xAF, 0x6A, S2, S1, S0, N, D2, D1, D0 raises `copy_valid_o` for one cycle, in the cycle after the final byte. At that point `copy_src_o`={S2,S1,S0}, `copy_cnt_o`=N and `copy_dst_o`={D2,D1,D0}. The register bank is not changed.
- R6: Where a lead byte is expected, any byte other than 0xAF is discarded. An opcode other than 0x20 or 0x6A abandons the command. In both cases decoding starts again at the next 0xAF, and no register changes.
- R7: A write to an address that is neither below NREG nor 0xFF changes nothing.
- R8: The decoded views follow the live bank:
  - `depth24_o` is bit 0 of register 0x00 (0 = 16 bpp, 1 = 24 bpp).
  - `blank_o` is register 0x1F.
  - `base16_o` is {0x20, 0x21, 0x22}.
  - `base8_o` is {0x26, 0x27, 0x28}.
  - `pclk_o` is {0x1C, 0x1B}, so the low byte sits at 0x1B.
- R9: On cycles where `in_valid` is low, `in_data` is ignored, the live bank does not change and neither strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte handshake |
| in_data | input | 8 | Stream byte |
| regs_o | output | NREG*8 | Live bank; register i at bits [8i+7:8i] |
| locked_o | output | 1 | Bank is locked |
| commit_o | output | 1 | One-cycle shadow-to-live commit strobe |
| copy_valid_o | output | 1 | One-cycle copy request strobe |
| copy_src_o | output | 24 | Copy source address |
| copy_cnt_o | output | 8 | Copy pixel count |
| copy_dst_o | output | 24 | Copy destination address |
| base16_o | output | 24 | 16 bpp base pointer view |
| base8_o | output | 24 | 8 bpp base pointer view |
| pclk_o | output | 16 | Pixel clock view |
| depth24_o | output | 1 | Colour depth select view |
| blank_o | output | 8 | Blanking control view |

## Verification
Every result is registered once. The live bank, the lock flag, the decoded views and both strobes therefore all change on the clock edge that accepts the final byte of a command. The bench drives each byte on a falling edge and lowers `in_valid` after one cycle. It then compares everything at the falling edge that follows the accepting rising edge, which is the only cycle in which a strobe is high. Idle cycles of random length, with random data on `in_data`, are placed between bytes. These idle cycles show that results depend only on accepted bytes.

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
  parameter int NREG = 48,
  parameter logic [7:0] LEAD = 8'hAF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic [NREG*8-1:0] regs_o,
  output logic              locked_o,
  output logic              commit_o,
  output logic              copy_valid_o,
  output logic [23:0]       copy_src_o,
  output logic [7:0]        copy_cnt_o,
  output logic [23:0]       copy_dst_o,
  output logic [23:0]       base16_o,
  output logic [23:0]       base8_o,
  output logic [15:0]       pclk_o,
  output logic              depth24_o,
  output logic [7:0]        blank_o
);
  localparam logic [7:0] OP_WR = 8'h20, OP_CP = 8'h6A, LOCK_ADDR = 8'hFF;
  localparam int BLANK_IX = 'h1F, CP_LAST = 6;

  typedef enum logic [1:0] {S_LEAD, S_OP, S_WR, S_CP} st_t;
  st_t         st;
  logic [2:0]  idx;
  logic [7:0]  addr_q;
  logic [47:0] cp_sh;
  logic [7:0]  live [NREG];
  logic [7:0]  shadow [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_LEAD;
      idx <= '0;
      addr_q <= '0;
      cp_sh <= '0;
      locked_o <= 1'b0;
      commit_o <= 1'b0;
      copy_valid_o <= 1'b0;
      copy_src_o <= '0;
      copy_cnt_o <= '0;
      copy_dst_o <= '0;
      for (int i = 0; i < NREG; i++) begin
        live[i]   <= (i == BLANK_IX) ? 8'h07 : 8'h00;
        shadow[i] <= (i == BLANK_IX) ? 8'h07 : 8'h00;
      end
    end else begin
      commit_o <= 1'b0;
      copy_valid_o <= 1'b0;
      if (in_valid) begin
        case (st)
          S_LEAD: if (in_data == LEAD) st <= S_OP;
          S_OP: begin
            idx <= '0;
            if (in_data == OP_WR)      st <= S_WR;
            else if (in_data == OP_CP) st <= S_CP;
            else                       st <= S_LEAD;
          end
          S_WR: begin
            if (idx == 3'd0) begin
              addr_q <= in_data;
              idx <= 3'd1;
            end else begin
              st <= S_LEAD;
              if (addr_q == LOCK_ADDR) begin
                if (in_data == 8'h00) locked_o <= 1'b1;
                else if (in_data == 8'hFF && locked_o) begin
                  locked_o <= 1'b0;
                  commit_o <= 1'b1;
                  for (int i = 0; i < NREG; i++) live[i] <= shadow[i];
                end
              end else begin
                for (int i = 0; i < NREG; i++)
                  if (addr_q == i[7:0]) begin
                    shadow[i] <= in_data;
                    if (!locked_o) live[i] <= in_data;
                  end
              end
            end
          end
          S_CP: begin
            cp_sh <= {cp_sh[39:0], in_data};
            idx <= idx + 3'd1;
            if (idx == 3'(CP_LAST)) begin
              st <= S_LEAD;
              copy_valid_o <= 1'b1;
              copy_src_o <= cp_sh[47:24];
              copy_cnt_o <= cp_sh[23:16];
              copy_dst_o <= {cp_sh[15:0], in_data};
            end
          end
          default: st <= S_LEAD;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = live[g];
  end

  assign depth24_o = live['h00][0];
  assign blank_o   = live[BLANK_IX];
  assign base16_o  = {live['h20], live['h21], live['h22]};
  assign base8_o   = {live['h26], live['h27], live['h28]};
  assign pclk_o    = {live['h1C], live['h1B]};
endmodule

module cmd_stream_decoder_chk #(parameter int NREG = 48) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [NREG*8-1:0] regs_o,
  input logic              locked_o,
  input logic              commit_o,
  input logic              copy_valid_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> !commit_o && !copy_valid_o && !locked_o); // R1
  AST_LOCKED_LIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) $past(locked_o) && locked_o |-> $stable(regs_o)); // R3
  AST_COMMIT_ENDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) commit_o |-> $past(locked_o) && !locked_o); // R4
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) commit_o |=> !commit_o); // R4
  AST_COPY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) copy_valid_o |=> !copy_valid_o); // R5
  AST_COPY_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n) copy_valid_o |-> $stable(regs_o)); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(commit_o && copy_valid_o)); // R5
  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) !$past(in_valid) |-> $stable(regs_o) && !commit_o && !copy_valid_o); // R9
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .regs_o(regs_o),
  .locked_o(locked_o), .commit_o(commit_o), .copy_valid_o(copy_valid_o));

// File: tb/sim_cmd_stream_decoder.sv
`timescale 1ns/1ps
module sim_cmd_stream_decoder;
  localparam int NREG = 48;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [NREG*8-1:0] regs_o;
  logic locked_o, commit_o, copy_valid_o, depth24_o;
  logic [23:0] copy_src_o, copy_dst_o, base16_o, base8_o;
  logic [7:0] copy_cnt_o, blank_o;
  logic [15:0] pclk_o;

  always #4 clk = ~clk;

  cmd_stream_decoder #(.NREG(NREG)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_live [NREG];
  logic [7:0] m_sh [NREG];
  bit m_lock;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++)
      if (bad < 0 && regs_o[i*8 +: 8] !== m_live[i]) bad = i;
    if (bad >= 0) chk({req, " bank"}, {32'(bad), 24'h0, regs_o[bad*8 +: 8]}, {32'(bad), 24'h0, m_live[bad]});
    else chk({req, " bank"}, 0, 0);
    chk({req, " lock"}, 64'(locked_o), 64'(m_lock));
  endtask

  task automatic send(logic [7:0] b);
    repeat ($urandom_range(0, 1)) @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'($urandom);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string req);
    bit ec = 0;
    send(8'hAF); send(8'h20); send(a); send(d);
    if (a == 8'hFF) begin
      if (d == 8'h00) m_lock = 1;
      else if (d == 8'hFF && m_lock) begin
        m_lock = 0; ec = 1;
        for (int i = 0; i < NREG; i++) m_live[i] = m_sh[i];
      end
    end else if (a < NREG) begin
      m_sh[a] = d;
      if (!m_lock) m_live[a] = d;
    end
    chk({req, " commit"}, 64'(commit_o), 64'(ec));
    check_bank(req);
  endtask

  task automatic cp(logic [23:0] s, logic [7:0] n, logic [23:0] d);
    send(8'hAF); send(8'h6A);
    send(s[23:16]); send(s[15:8]); send(s[7:0]); send(n);
    send(d[23:16]); send(d[15:8]); send(d[7:0]);
    chk("R5 copy_valid", 64'(copy_valid_o), 1);
    chk("R5 fields", {copy_src_o, copy_cnt_o, copy_dst_o}, {s, n, d});
    check_bank("R5");
  endtask

  task automatic garbage();
    logic [7:0] b;
    do b = 8'($urandom); while (b == 8'hAF);
    send(b);
  endtask

  task automatic bad_op();
    logic [7:0] b;
    do b = 8'($urandom); while (b == 8'h20 || b == 8'h6A);
    send(8'hAF); send(b);
    chk("R6 no strobe", {63'h0, commit_o | copy_valid_o}, 0);
  endtask

  task automatic check_views();
    chk("R8 depth", 64'(depth24_o), 64'(m_live['h00][0]));
    chk("R8 blank", 64'(blank_o), 64'(m_live['h1F]));
    chk("R8 base16", 64'(base16_o), 64'({m_live['h20], m_live['h21], m_live['h22]}));
    chk("R8 base8", 64'(base8_o), 64'({m_live['h26], m_live['h27], m_live['h28]}));
    chk("R8 pclk", 64'(pclk_o), 64'({m_live['h1C], m_live['h1B]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_lock = 0;
    for (int i = 0; i < NREG; i++) begin
      m_live[i] = (i == 'h1F) ? 8'h07 : 8'h00;
      m_sh[i] = m_live[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bank("R1");
    chk("R1 blank", 64'(blank_o), 64'h07);
    chk("R1 strobes", {62'h0, commit_o, copy_valid_o}, 0);

    wr(8'h20, 8'h12, "R2"); wr(8'h21, 8'h34, "R2"); wr(8'h22, 8'h56, "R2");
    chk("R8 base16 order", 64'(base16_o), 64'h123456);
    wr(8'h1B, 8'h34, "R2"); wr(8'h1C, 8'h12, "R2");
    chk("R8 pclk low first", 64'(pclk_o), 64'h1234);
    wr(8'h00, 8'h01, "R2");
    chk("R8 depth24", 64'(depth24_o), 1);
    wr(8'h1F, 8'h00, "R2");
    check_views();

    wr(8'hFF, 8'h00, "R3 lock");
    wr(8'h05, 8'hAA, "R3 locked write");
    wr(8'h1F, 8'h05, "R3 locked write");
    wr(8'hFF, 8'h55, "R4 other value");
    wr(8'hFF, 8'hFF, "R4 unlock commit");
    chk("R4 committed value", 64'(regs_o[5*8 +: 8]), 64'hAA);
    wr(8'hFF, 8'hFF, "R4 unlock while unlocked");
    wr(8'h40, 8'h99, "R7 out of range");
    wr(8'hFE, 8'h99, "R7 out of range");

    garbage(); garbage(); garbage();
    wr(8'h07, 8'h3C, "R6 after garbage");
    bad_op();
    check_bank("R6 bad opcode");
    wr(8'h08, 8'hC3, "R6 after bad opcode");
    cp(24'h010203, 8'h01, 24'hA0B0C0);
    cp(24'hFFFFFF, 8'hFF, 24'h000000);
    check_views();

    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(0, 19);
      if (kind < 10) wr(8'($urandom_range(0, NREG - 1)), 8'($urandom), "R2 random");
      else if (kind < 12) wr(8'hFF, 8'h00, "R3 random lock");
      else if (kind < 14) wr(8'hFF, 8'hFF, "R4 random unlock");
      else if (kind == 14) wr(8'($urandom_range(NREG, 254)), 8'($urandom), "R7 random");
      else if (kind == 15) begin garbage(); check_bank("R6 random garbage"); end
      else if (kind == 16) begin bad_op(); check_bank("R6 random opcode"); end
      else if (kind == 17) begin
        repeat ($urandom_range(1, 4)) @(negedge clk);
        check_bank("R9 idle");
      end
      else cp(24'($urandom), 8'($urandom), 24'($urandom));
      if (k % 25 == 0) check_views();
    end
    check_views();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule